// File: doc/BRIEF.md
# Harmonic Spur Cancellation Channel

This block sits on the amplitude stream of a direct digital synthesizer and injects correction tones at chosen harmonics of the synthesized fundamental. The aim is to cancel spurs of known amplitude and phase. Each of two independent channels works from the accumulator phase of the synthesizer. It multiplies that phase by a harmonic number and adds a programmable phase offset. A parabolic sine shaper turns the result into a tone, which is scaled by a programmable magnitude and can be doubled by a gain bit. Both tones are added to the signed 14-bit sample, and the sum saturates rather than wraps.

Control values for each channel are presented on shadow inputs. They are copied into the working set only when the shared update strobe is high at a clock edge. Software can therefore change every field of both channels and have the changes take effect on the same sample. The datapath has two register stages. The harmonic phase and the controls are registered in the first stage. The shaped, scaled and saturated sum is registered in the second.

Top module: `spur_cancel`

## Requirements
- R1: Two channels, index 0 and index 1, each add their own correction term to the sample, and the output is the input sample plus the sum of both terms.
- R2: A channel's phase is theta = (h * phase_i + poff * 256) mod 65536, where h is the channel's 4-bit harmonic and poff is its 8-bit phase offset.
- R3: The tone is s = a when bit 15 of theta is 0 and s = -a otherwise. Here a = (u * (32768 - u)) >> 18, with u equal to theta mod 32768, so |s| never exceeds 1024.
- R4: The correction term is c = floor(s * mag / 256), with mag an unsigned 8-bit magnitude. When the channel's gain bit is 1, the term is 2*c.
- R5: A channel contributes exactly zero when its enable bit is 0, when its harmonic is 0, or when its magnitude is 0.
- R6: The sum saturates to 8191 above and to -8192 below.
- R7: Values on the control inputs reach the working set only at a clock edge where io_update_i is 1. The new set applies from the data sampled at the following edge, and changes made without the strobe have no effect.
- R8: sample_o reflects the data sampled two rising edges earlier. It reads 0 during reset, and after reset every channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 16 | Accumulator phase |
| sample_i | input | 14 | Signed input sample |
| io_update_i | input | 1 | Copies shadow controls into the working set |
| en_i | input | 2 | Channel enable, one bit per channel |
| harm_i | input | 2x4 | Harmonic number per channel |
| mag_i | input | 2x8 | Magnitude per channel |
| poff_i | input | 2x8 | Phase offset per channel |
| gain2_i | input | 2 | Gain-times-two per channel |
| sample_o | output | 14 | Signed corrected, saturated sample |

## Verification
Each output is due on the second rising edge after its phase and sample are applied. The bench drives its inputs on falling edges and keeps a two-deep queue of expected values. On every falling edge it compares sample_o with the entry computed two falling edges earlier. A control update takes effect one edge later than the data sampled together with the strobe. The bench model therefore computes each expected value from the working set it holds, and only then copies the shadow values into that set. This keeps the expected values aligned with update strobes and with shadow changes made without a strobe.

// File: rtl/spur_pkg.sv
package spur_pkg;
  localparam int HARM_W = 4;
  localparam int CTL_W  = 8;

  typedef struct packed {
    logic              en;
    logic [HARM_W-1:0] harm;
    logic [CTL_W-1:0]  mag;
    logic [CTL_W-1:0]  poff;
    logic              gain2;
  } spur_cfg_t;
endpackage

// File: rtl/spur_cfg_regs.sv
module spur_cfg_regs
  import spur_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 io_update_i,
  input  spur_cfg_t [NCH-1:0]  shadow_i,
  output spur_cfg_t [NCH-1:0]  active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          active_o <= '0;
    else if (io_update_i) active_o <= shadow_i;
  end

  // R7: working set moves only on the strobe
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_update_i |=> $stable(active_o));
  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_update_i |=> active_o == $past(shadow_i));
endmodule

// File: rtl/spur_channel.sv
module spur_channel
  import spur_pkg::*;
#(
  parameter int PW = 16,
  parameter int SW = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PW-1:0]       phase_i,
  input  spur_cfg_t           cfg_i,
  output logic signed [SW:0]  corr_o
);
  localparam int HALF_W = PW - 1;
  localparam int PROD_W = 2 * HALF_W + 1;
  localparam int SHIFT  = 2 * HALF_W - 2 - (SW - 2);
  localparam int MUL_W  = SW + CTL_W + 1;

  logic [PW+HARM_W-1:0] hp_full;
  logic [PW-1:0]        theta_d, theta_q;
  logic [CTL_W-1:0]     mag_q;
  logic                 gain_q, live_q;

  assign hp_full = (PW+HARM_W)'(phase_i) * (PW+HARM_W)'(cfg_i.harm);
  assign theta_d = hp_full[PW-1:0] + {cfg_i.poff, {(PW-CTL_W){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      theta_q <= '0;
      mag_q   <= '0;
      gain_q  <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      theta_q <= theta_d;
      mag_q   <= cfg_i.mag;
      gain_q  <= cfg_i.gain2;
      live_q  <= cfg_i.en && (cfg_i.harm != '0);
    end
  end

  // parabolic half-wave shaper
  logic [HALF_W-1:0]       u;
  logic [HALF_W:0]         rem;
  logic [PROD_W-1:0]       prod;
  logic [SW-2:0]           amp;
  logic signed [SW-1:0]    sine;
  logic signed [MUL_W-1:0] sine_x, mag_x, scaled_p, scaled;

  assign u    = theta_q[HALF_W-1:0];
  assign rem  = {1'b1, {HALF_W{1'b0}}} - {1'b0, u};
  assign prod = PROD_W'(u) * PROD_W'(rem);
  assign amp  = prod[SHIFT +: SW-1];
  assign sine = theta_q[PW-1] ? -$signed({1'b0, amp}) : $signed({1'b0, amp});

  assign sine_x   = {{(CTL_W+1){sine[SW-1]}}, sine};
  assign mag_x    = {{(SW+1){1'b0}}, mag_q};
  assign scaled_p = sine_x * mag_x;
  assign scaled   = scaled_p >>> CTL_W;

  always_comb begin
    if (!live_q)     corr_o = '0;
    else if (gain_q) corr_o = {scaled[SW-1:0], 1'b0};
    else             corr_o = {scaled[SW-1], scaled[SW-1:0]};
  end

  // R5: muted channel yields zero one stage later
  assert_mute_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> corr_o == '0);
  assert_mute_mag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.mag == '0) |=> corr_o == '0);
  assert_mute_harm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.harm == '0) |=> corr_o == '0);
endmodule

// File: rtl/spur_sat_sum.sv
module spur_sat_sum #(
  parameter int NCH = 2,
  parameter int DW  = 14,
  parameter int CW  = 13
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic signed [DW-1:0]         sample_i,
  input  logic signed [NCH-1:0][CW-1:0] corr_i,
  output logic signed [DW-1:0]         sample_o
);
  localparam int SUM_W = DW + $clog2(NCH + 1) + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((2 ** (DW - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SUM_W'(2 ** (DW - 1));

  logic signed [DW-1:0]    sample_q;
  logic signed [SUM_W-1:0] sum_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_q <= '0;
    else         sample_q <= sample_i;
  end

  always_comb begin
    sum_w = {{(SUM_W-DW){sample_q[DW-1]}}, sample_q};
    for (int c = 0; c < NCH; c++)
      sum_w = sum_w + {{(SUM_W-CW){corr_i[c][CW-1]}}, corr_i[c]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              sample_o <= '0;
    else if (sum_w > SAT_HI)  sample_o <= SAT_HI[DW-1:0];
    else if (sum_w < SAT_LO)  sample_o <= SAT_LO[DW-1:0];
    else                      sample_o <= sum_w[DW-1:0];
  end

  assert_no_wrap_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_w > SAT_HI) |=> sample_o == SAT_HI[DW-1:0]);
  assert_no_wrap_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_w < SAT_LO) |=> sample_o == SAT_LO[DW-1:0]);
endmodule

// File: rtl/spur_cancel.sv
module spur_cancel
  import spur_pkg::*;
#(
  parameter int NCH = 2,
  parameter int PW  = 16,
  parameter int DW  = 14,
  parameter int SW  = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [PW-1:0]                 phase_i,
  input  logic signed [DW-1:0]          sample_i,
  input  logic                          io_update_i,
  input  logic [NCH-1:0]                en_i,
  input  logic [NCH-1:0][HARM_W-1:0]    harm_i,
  input  logic [NCH-1:0][CTL_W-1:0]     mag_i,
  input  logic [NCH-1:0][CTL_W-1:0]     poff_i,
  input  logic [NCH-1:0]                gain2_i,
  output logic signed [DW-1:0]          sample_o
);
  localparam int CW = SW + 1;

  spur_cfg_t [NCH-1:0]          shadow, active;
  logic signed [NCH-1:0][CW-1:0] corr;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      shadow[c].en    = en_i[c];
      shadow[c].harm  = harm_i[c];
      shadow[c].mag   = mag_i[c];
      shadow[c].poff  = poff_i[c];
      shadow[c].gain2 = gain2_i[c];
    end
  end

  spur_cfg_regs #(.NCH(NCH)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .io_update_i(io_update_i),
    .shadow_i   (shadow),
    .active_o   (active)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [CW-1:0] corr_c;
    spur_channel #(.PW(PW), .SW(SW)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .phase_i(phase_i),
      .cfg_i  (active[c]),
      .corr_o (corr_c)
    );
    assign corr[c] = corr_c;
  end

  spur_sat_sum #(.NCH(NCH), .DW(DW), .CW(CW)) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_i),
    .corr_i  (corr),
    .sample_o(sample_o)
  );
endmodule

// File: tb/spur_cancel_tb.sv
module spur_cancel_tb;
  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic              rst_ni;
  logic [15:0]       phase_i;
  logic signed [13:0] sample_i;
  logic              io_update_i;
  logic [1:0]        en_i, gain2_i;
  logic [1:0][3:0]   harm_i;
  logic [1:0][7:0]   mag_i, poff_i;
  logic signed [13:0] sample_o;

  spur_cancel u_dut (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;
  string tag = "R8";

  int sh_en[2], sh_h[2], sh_m[2], sh_p[2], sh_g[2];
  int ac_en[2], ac_h[2], ac_m[2], ac_p[2], ac_g[2];
  longint exp0 = 0, exp1 = 0;

  function automatic longint corr_f(longint ph, int en, int h, int m, int p, int g);
    longint th, u, a, s, c;
    if (en == 0 || h == 0) return 0;
    th = (ph * h + p * 256) % 65536;
    u  = th % 32768;
    a  = (u * (32768 - u)) >> 18;
    s  = (th >= 32768) ? -a : a;
    c  = (s * m) >>> 8;
    return (g != 0) ? 2 * c : c;
  endfunction

  function automatic longint model(longint ph, longint smp);
    longint t;
    t = smp;
    for (int c = 0; c < 2; c++) t += corr_f(ph, ac_en[c], ac_h[c], ac_m[c], ac_p[c], ac_g[c]);
    if (t > 8191) t = 8191;
    if (t < -8192) t = -8192;
    return t;
  endfunction

  task automatic chk(longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: sample_o actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_ch(int c, int en, int h, int m, int p, int g);
    sh_en[c] = en; sh_h[c] = h; sh_m[c] = m; sh_p[c] = p; sh_g[c] = g;
  endtask

  task automatic step(int ph, int smp, bit upd);
    @(negedge clk_i);
    chk(longint'(sample_o), exp1);
    exp1 = exp0;
    exp0 = model(ph, smp);
    phase_i = 16'(ph);
    sample_i = 14'(smp);
    io_update_i = upd;
    for (int c = 0; c < 2; c++) begin
      en_i[c] = sh_en[c][0]; harm_i[c] = 4'(sh_h[c]); mag_i[c] = 8'(sh_m[c]);
      poff_i[c] = 8'(sh_p[c]); gain2_i[c] = sh_g[c][0];
    end
    if (upd) begin
      ac_en = sh_en; ac_h = sh_h; ac_m = sh_m; ac_p = sh_p; ac_g = sh_g;
    end
  endtask

  task automatic flush();
    step(0, 0, 0); step(0, 0, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 2; c++) begin
      set_ch(c, 0, 0, 0, 0, 0);
      ac_en[c] = 0; ac_h[c] = 0; ac_m[c] = 0; ac_p[c] = 0; ac_g[c] = 0;
    end
    rst_ni = 1'b0; phase_i = '0; sample_i = '0; io_update_i = 1'b0;
    en_i = '0; harm_i = '0; mag_i = '0; poff_i = '0; gain2_i = '0;
    repeat (3) @(negedge clk_i);
    tag = "R8"; chk(longint'(sample_o), 0);  // R8 reset value
    rst_ni = 1'b1;

    // R8: channels off after reset, plain pass-through with latency two
    tag = "R8";
    step(100, 1234, 0); step(200, -777, 0); step(300, 8191, 0); step(400, -8192, 0);
    flush();

    // R4: channel 0 at quarter phase, full magnitude -> 1020
    tag = "R4";
    set_ch(0, 1, 1, 255, 64, 0);
    step(0, 0, 1); step(0, 0, 0); step(0, 0, 0); flush();
    // R4: gain doubles -> 2040
    set_ch(0, 1, 1, 255, 64, 1);
    step(0, 0, 1); step(0, 10, 0); flush();

    // R6: both channels positive on a full-scale sample
    tag = "R6";
    set_ch(1, 1, 1, 255, 64, 1);
    step(0, 8191, 1); step(0, 8000, 0); step(0, 7000, 0); flush();
    set_ch(0, 1, 1, 255, 192, 1); set_ch(1, 1, 1, 255, 192, 1);
    step(0, -8192, 1); step(0, -6000, 0); step(0, -4000, 0); flush();

    // R7: shadow change without strobe has no effect
    tag = "R7";
    set_ch(0, 1, 3, 17, 5, 0); set_ch(1, 0, 2, 99, 0, 0);
    step(0, 50, 0); step(0, 50, 0); step(1000, 50, 0); flush();
    step(0, 50, 1); step(0, 50, 0); step(1000, 50, 0); flush();

    // R5: harmonic zero and magnitude zero mute
    tag = "R5";
    set_ch(0, 1, 0, 200, 64, 1); set_ch(1, 1, 5, 0, 64, 1);
    step(0, 321, 1); step(4096, 321, 0); step(9999, -321, 0); flush();

    // R2/R3: harmonic multiply wraps modulo 2^16
    tag = "R2";
    set_ch(0, 1, 15, 255, 0, 0); set_ch(1, 0, 0, 0, 0, 0);
    step(16'h1111, 0, 1);
    for (int i = 0; i < 40; i++) step(i * 1640, 0, 0);
    tag = "R3";
    set_ch(0, 1, 1, 255, 0, 0);
    step(0, 0, 1);
    for (int i = 0; i < 64; i++) step(i * 1024, 0, 0);
    flush();

    // R1: random stimulus on both channels with occasional updates
    tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      bit upd;
      upd = ($urandom % 16) == 0;
      if (($urandom % 8) == 0)
        for (int c = 0; c < 2; c++)
          set_ch(c, int'($urandom % 4 != 0), int'($urandom % 16), int'($urandom % 256),
                 int'($urandom % 256), int'($urandom % 2));
      step(int'($urandom % 65536), int'($urandom % 16384) - 8192, upd);
    end
    flush();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule